// File: doc/BRIEF.md
# Multi-Source Reset Distributor

This block forms the chip-wide reset and hands a separately conditioned copy of it to every clock domain. A global reset input and a set of reset request lines from components such as a watchdog are merged into one combined reset. Any one of these sources is enough to reset the whole system, and a request line has exactly the same effect as the global input.

Each clock domain has its own short flip-flop chain clocked by that domain's clock. The combined reset presets the chain asynchronously. The domain's reset output therefore rises at once, without waiting for a clock edge. Once every source is low, the chain shifts in the released level on each rising edge of its own clock, so the output falls cleanly aligned to that domain.

The number of domains, the number of request lines and the chain depth are parameters. A depth below two is raised to two. All pins are plain active-high levels. There is no handshake on any of them.

Top module: `sys_reset_fanout`

## Requirements
- R1: While `glb_rst_in` is high, every bit of `dom_rst_out` is high.
- R2: Each domain has its own output bit, and each bit is released by its own clock `clk_dom[d]` independently of the other domains. A fast domain can be out of reset while a slow domain is still held.
- R3: When any source rises, every output bit goes high within the same time step, with no clock edge in between.
- R4: Once an output bit rises, it is still high at the next rising edge of its domain's clock, even when the source pulse was shorter than one clock period.
- R5: While any bit of `rst_req` is high, every bit of `dom_rst_out` is high, exactly as for the global input.
- R6: Every output bit stays high for as long as at least one source is high, no matter how many clock edges pass.
- R7: After the last source falls, bit d of `dom_rst_out` falls on exactly the SYNC_DEPTH-th rising edge of `clk_dom[d]`, counted from the fall (default SYNC_DEPTH = 2). It does not fall on any earlier edge.
- R8: When sources overlap, dropping one of them while another is still high leaves every output bit high. Release starts only when the last source drops.
- R9: With `glb_rst_in` high from time zero, all output bits read high before the first clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_dom | input | NUM_DOMAINS | One clock per domain; bit d clocks the release chain of domain d |
| glb_rst_in | input | 1 | Global reset, active high |
| rst_req | input | NUM_REQ | Reset request lines from components, active high |
| dom_rst_out | output | NUM_DOMAINS | Conditioned reset for each domain, active high |

## Verification
The bench drives three domain clocks with unrelated periods. This means the same release lands on different edge counts in each domain, which separates a true per-domain chain from one shared chain.

Directed patterns cover several cases:
- The global input alone, and a single request line alone. These confirm that either source type resets the system.
- A source raised between clock edges. This shows that assertion is asynchronous.
- A pulse shorter than half a clock period. This exposes a chain that would let the output drop after a single edge.
- Overlapping global and request pulses. These show that release waits for the last source.

Random mixes of request bits and hold times are then compared, step by step, with an edge-counting model. This catches a release that comes one edge early or one edge late.

// File: rtl/rstd_pkg.sv
package rstd_pkg;

  // Smallest chain that still gives a full clock period of reset after release starts.
  localparam int unsigned MIN_SYNC_STAGES = 2;

  // Clamp a requested chain depth to the legal minimum.
  function automatic int unsigned legal_depth(input int unsigned requested);
    return (requested < MIN_SYNC_STAGES) ? MIN_SYNC_STAGES : requested;
  endfunction

endpackage

// File: rtl/rstd_merge.sv
// Merges the global reset with all component request lines into one level.
module rstd_merge #(
  parameter int unsigned NUM_REQ = 4
) (
  input  logic               glb_in,
  input  logic [NUM_REQ-1:0] req_in,
  output logic               merged_out
);

  // Build the OR as a chain of partial terms so every source enters on equal footing.
  logic [NUM_REQ:0] partial;

  assign partial[0] = glb_in;

  for (genvar i = 0; i < NUM_REQ; i++) begin : g_or
    assign partial[i+1] = partial[i] | req_in[i];
  end

  assign merged_out = partial[NUM_REQ];

endmodule

// File: rtl/rstd_release_sync.sv
// Per-domain chain: preset asynchronously, drained one stage per clock edge.
module rstd_release_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_in,
  output logic rst_out
);

  import rstd_pkg::*;

  localparam int unsigned DEPTH = legal_depth(STAGES);

  logic [DEPTH-1:0] chain;

  always_ff @(posedge clk or posedge arst_in) begin
    if (arst_in) begin
      chain <= '1;
    end else begin
      chain <= {chain[DEPTH-2:0], 1'b0};
    end
  end

  assign rst_out = chain[DEPTH-1];

endmodule

// File: rtl/sys_reset_fanout.sv
// System reset merge and per-domain fan-out.
module sys_reset_fanout #(
  parameter int unsigned NUM_DOMAINS = 3,
  parameter int unsigned NUM_REQ     = 4,
  parameter int unsigned SYNC_DEPTH  = 2
) (
  input  logic [NUM_DOMAINS-1:0] clk_dom,
  input  logic                   glb_rst_in,
  input  logic [NUM_REQ-1:0]     rst_req,
  output logic [NUM_DOMAINS-1:0] dom_rst_out
);

  logic sys_rst;

  rstd_merge #(
    .NUM_REQ (NUM_REQ)
  ) u_merge (
    .glb_in     (glb_rst_in),
    .req_in     (rst_req),
    .merged_out (sys_rst)
  );

  for (genvar d = 0; d < NUM_DOMAINS; d++) begin : g_domain
    rstd_release_sync #(
      .STAGES (SYNC_DEPTH)
    ) u_sync (
      .clk     (clk_dom[d]),
      .arst_in (sys_rst),
      .rst_out (dom_rst_out[d])
    );
  end

endmodule

// File: rtl/rstd_checker.sv
// Properties for sys_reset_fanout, attached by bind below.
module rstd_checker #(
  parameter int unsigned NUM_DOMAINS = 3,
  parameter int unsigned NUM_REQ     = 4,
  parameter int unsigned SYNC_DEPTH  = 2
) (
  input logic [NUM_DOMAINS-1:0] clk_dom,
  input logic                   glb_rst_in,
  input logic [NUM_REQ-1:0]     rst_req,
  input logic [NUM_DOMAINS-1:0] dom_rst_out
);

  import rstd_pkg::*;

  localparam int unsigned EFF = legal_depth(SYNC_DEPTH);
  localparam int unsigned CW  = $clog2(EFF + 1);

  logic any_src;
  assign any_src = glb_rst_in | (|rst_req);

  for (genvar g = 0; g < NUM_DOMAINS; g++) begin : g_chk
    logic          armed = 1'b0;
    logic [CW-1:0] edges;

    always @(posedge clk_dom[g]) armed <= 1'b1;

    // Rising edges of this domain since every source went low, saturating.
    always @(posedge clk_dom[g] or posedge any_src) begin
      if (any_src)                edges <= '0;
      else if (edges < CW'(EFF))  edges <= edges + 1'b1;
    end

    // R1: the global input holds every domain in reset
    p_glb_forces_r1: assert property (@(posedge clk_dom[g]) disable iff (!armed)
      glb_rst_in |-> dom_rst_out[g]);

    // R5 and R6: any request line holds every domain in reset
    p_req_forces_r5: assert property (@(posedge clk_dom[g]) disable iff (!armed)
      (|rst_req) |-> dom_rst_out[g]);

    // R4: a rising reset survives at least the following edge
    p_min_pulse_r4: assert property (@(posedge clk_dom[g]) disable iff (!armed)
      $rose(dom_rst_out[g]) |=> dom_rst_out[g]);

    // R7: the output is released exactly when SYNC_DEPTH edges have passed
    p_exact_release_r7: assert property (@(posedge clk_dom[g]) disable iff (!armed || any_src)
      (edges >= CW'(EFF)) == !dom_rst_out[g]);
  end

endmodule

bind sys_reset_fanout rstd_checker #(
  .NUM_DOMAINS (NUM_DOMAINS),
  .NUM_REQ     (NUM_REQ),
  .SYNC_DEPTH  (SYNC_DEPTH)
) i_rstd_checker (
  .clk_dom     (clk_dom),
  .glb_rst_in  (glb_rst_in),
  .rst_req     (rst_req),
  .dom_rst_out (dom_rst_out)
);

// File: tb/test_sys_reset_fanout.sv
`timescale 1ns/10ps
module test_sys_reset_fanout;

  localparam int ND = 3;
  localparam int NR = 4;
  localparam int SD = 2;

  logic          c0 = 1'b0, c1 = 1'b0, c2 = 1'b0;
  logic [ND-1:0] clk_v;
  logic          glb;
  logic [NR-1:0] req;
  logic [ND-1:0] dout;

  int  n_checks = 0;
  int  n_err    = 0;
  bit  done     = 1'b0;

  // Domain 0 runs at 200 MHz; the others use unrelated periods.
  always #2.5 c0 = ~c0;
  always #3.5 c1 = ~c1;
  always #5.5 c2 = ~c2;
  assign clk_v = {c2, c1, c0};

  sys_reset_fanout #(
    .NUM_DOMAINS (ND),
    .NUM_REQ     (NR),
    .SYNC_DEPTH  (SD)
  ) i_sys_reset_fanout (
    .clk_dom     (clk_v),
    .glb_rst_in  (glb),
    .rst_req     (req),
    .dom_rst_out (dout)
  );

  // Reference model: OR of all sources (R1, R5), per-domain edge count since release (R7).
  logic src_m;
  assign src_m = glb | (|req);
  int mcnt [ND];

  for (genvar d = 0; d < ND; d++) begin : g_model
    always @(posedge clk_v[d] or posedge src_m) begin
      if (src_m)           mcnt[d] <= 0;
      else if (mcnt[d] < SD) mcnt[d] <= mcnt[d] + 1;
    end
  end

  function automatic logic [ND-1:0] model_out();
    logic [ND-1:0] r;
    for (int d = 0; d < ND; d++) r[d] = (mcnt[d] < SD);
    return r;
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [ND-1:0] act, input logic [ND-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_model(input string tag);
    logic [ND-1:0] e;
    e = model_out();
    check(dout === e, tag, dout, e);
  endtask

  // Advance one half-nanosecond step on the off-edge grid, then compare with the model.
  task automatic step(input string tag);
    #0.5;
    chk_model(tag);
  endtask

  initial begin
    glb = 1'b1;
    req = '0;
    void'($urandom(32'd20240611));
    #0.25;
    check(dout === '1, "R9 reset state", dout, '1);

    // R1 / R6: global reset held over many edges
    for (int i = 0; i < 40; i++) step("R1 global held");
    check(dout === '1, "R6 held all high", dout, '1);

    // R7 / R2: release and count domain 0 edges exactly
    glb = 1'b0;
    repeat (SD - 1) @(posedge c0);
    #0.25;
    check(dout[0] === 1'b1, "R7 not before depth", {2'b00, dout[0]}, 3'b001);
    check(dout[2] === 1'b1, "R2 slow domain held", {dout[2], 2'b00}, 3'b100);
    @(posedge c0);
    #0.25;
    check(dout[0] === 1'b0, "R7 release at depth", {2'b00, dout[0]}, 3'b000);
    check(dout[2] === 1'b1, "R2 independent release", {dout[2], 2'b00}, 3'b100);
    for (int i = 0; i < 60; i++) step("R7 release model");
    check(dout === '0, "R7 all released", dout, '0);

    // R3 / R5: a single request asserts everything without a clock edge
    req[2] = 1'b1;
    #0.1;
    check(dout === '1, "R3 async assert by R5 request", dout, '1);
    #0.4;
    for (int i = 0; i < 20; i++) step("R5 request held");

    // R8: overlapping sources, drop the request first
    glb = 1'b1;
    for (int i = 0; i < 6; i++) step("R8 overlap");
    req[2] = 1'b0;
    for (int i = 0; i < 30; i++) step("R8 request dropped");
    check(dout === '1, "R8 still held by global", dout, '1);
    glb = 1'b0;
    for (int i = 0; i < 60; i++) step("R8 release after last");
    check(dout === '0, "R8 released", dout, '0);

    // R4: half-nanosecond pulse on one request line
    req[1] = 1'b1;
    #0.1;
    check(dout === '1, "R4 short pulse asserts", dout, '1);
    #0.4;
    req[1] = 1'b0;
    @(posedge c0);
    #0.25;
    check(dout[0] === 1'b1, "R4 survives next edge", {2'b00, dout[0]}, 3'b001);
    for (int i = 0; i < 60; i++) step("R4 model");

    // Random mixes of sources and hold times (R5, R6, R7)
    for (int it = 0; it < 400; it++) begin
      int hold;
      glb = ($urandom_range(0, 9) == 0);
      for (int b = 0; b < NR; b++) req[b] = ($urandom_range(0, 6) == 0);
      hold = $urandom_range(1, 40);
      for (int s = 0; s < hold; s++) step("R6 random");
    end
    glb = 1'b0;
    req = '0;
    for (int i = 0; i < 60; i++) step("R7 random tail");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

endmodule